// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block moves one byte at a time over a three-wire synchronous link: data out, data in and a serial clock. It works as a master or as a slave. As master it drives the serial clock from a divided system clock, at one of four selectable rates. As slave it follows an external clock that it samples into the system clock domain. Data is always launched on the falling edge of the serial clock and sampled on the rising edge. A configuration bit only selects whether the clock rests high or low between transfers. Another bit selects the bit order.

Software loads the outgoing byte through a valid/ready stream port. A byte is taken only on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low whenever the port is disabled, a transfer is running, or a configuration write is aborting one. A held `tx_valid` therefore waits and is never dropped. In master mode an accepted byte starts the exchange at once. In slave mode it is preloaded and shifted out as the remote master clocks. When eight bits have moved, the received byte lands in a holding register, a completion flag rises and the interrupt request follows that flag. While the port is disabled, a select output hands the three pins back to general-purpose I/O.

Top module: `sio_port`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x00 and `done_flag`, `irq`, `pin_sel` and `sck_oe` are all 0. This places the port disabled, in slave mode, MSB-first, at the slowest rate.
- R2: The configuration byte uses these fields: bit 0 enable, bit 1 LSB-first, bit 2 master, bit 3 flag-clear strobe, bit 4 clock-idles-low, bits 6:5 rate and bit 7 reserved, which reads 0. `pin_sel` equals the enable bit. `sck_oe` is high exactly when both enable and master are set.
- R3: `tx_ready` is high only while the port is enabled and idle. In master mode an accepted byte is exchanged over eight clock periods. With LSB-first at 0 the MSB goes first and the first bit received ends up in bit 7.
- R4: With LSB-first at 1, both directions carry bit 0 first.
- R5: In master mode the serial clock half-period is 32, 16, 8 or 2 system clocks for rate codes 00, 01, 10 and 11.
- R6: `sdo` changes only on falling serial clock edges and `sdi` is sampled on rising edges. Between transfers the serial clock sits low when bit 4 is 1 and high when it is 0.
- R7: After the eighth bit the received byte appears on `rx_data`, `done_flag` is set and `irq` mirrors it. The serial clock is back at its idle level.
- R8: Writing the configuration with bit 3 at 1 clears `done_flag`. Bit 3 at 0 leaves the flag alone, and bit 3 always reads 0.
- R9: A `tx_valid` pulse during a transfer is not accepted and does not alter the byte being sent.
- R10: Clearing enable mid-transfer stops the transfer, drops `pin_sel` and `sck_oe`, and resets the bit counter. No completion follows, and the next transfer is complete and correct.
- R11: Clearing master mid-transfer also aborts it without completion, and the port then accepts a new byte.
- R12: In slave mode the byte is exchanged on an external `sck_in` whose period is at least four system clocks. It is sampled through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Configuration write strobe |
| ctrl_wdata | input | 8 | Configuration write byte |
| ctrl_rdata | output | 8 | Configuration readback |
| tx_valid | input | 1 | Outgoing byte offered |
| tx_data | input | 8 | Outgoing byte |
| tx_ready | output | 1 | Port can accept a byte |
| rx_data | output | 8 | Last received byte |
| done_flag | output | 1 | Transfer-complete flag |
| irq | output | 1 | Interrupt request |
| pin_sel | output | 1 | 1: pins serve the serial port |
| sck_in | input | 1 | External serial clock (slave) |
| sck_out | output | 1 | Driven serial clock (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The master exchange is run with asymmetric byte pairs, such as 0xA5 out with 0x3C in, once in each bit order. A mirrored or swapped order shows up as a wrong byte in both directions. A transfer with the clock resting high and one with it resting low separate the leading-fall case from the trailing-fall case. The rate codes are each timed between two clock toggles. The slave run uses a byte whose bits differ from those of the master patterns, to expose a wrong sampling edge. The abort runs restart with a fresh byte, so a stale bit counter would corrupt the result.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [1:0] rate;
    logic       idle_low;
    logic       master;
    logic       lsb_first;
    logic       enable;
  } sio_cfg_t;

  function automatic logic [BYTE_W-1:0] cfg_to_byte(input sio_cfg_t c);
    return {1'b0, c.rate, c.idle_low, 1'b0, c.master, c.lsb_first, c.enable};
  endfunction
endpackage

// File: rtl/sio_ctrl_reg.sv
module sio_ctrl_reg
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              finish,
  output sio_cfg_t          cfg,
  output logic              flag,
  output logic              abort,
  output logic [BYTE_W-1:0] rdata
);
  logic wr_off, wr_mode_flip;

  assign wr_off       = we && !wdata[0];
  assign wr_mode_flip = we && (wdata[2] != cfg.master);
  assign abort        = !cfg.enable || wr_off || wr_mode_flip;
  assign rdata        = cfg_to_byte(cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      flag <= 1'b0;
    end else begin
      if (we) begin
        cfg.enable    <= wdata[0];
        cfg.lsb_first <= wdata[1];
        cfg.master    <= wdata[2];
        cfg.idle_low  <= wdata[4];
        cfg.rate      <= wdata[6:5];
      end
      if (finish)
        flag <= 1'b1;
      else if (we && wdata[3])
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
  parameter int DIV_R0 = 64,
  parameter int DIV_R1 = 32,
  parameter int DIV_R2 = 16,
  parameter int DIV_R3 = 4,
  parameter int BITS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       start,
  input  logic [1:0] rate,
  input  logic       idle_low,
  output logic       sck,
  output logic       active,
  output logic       rise,
  output logic       fall,
  output logic       done
);
  localparam int HALF_MAX = DIV_R0 / 2;
  localparam int CW       = $clog2(HALF_MAX) + 1;
  localparam int TOGGLES  = 2 * BITS;
  localparam int TW       = $clog2(TOGGLES);

  logic [CW-1:0] cnt, reload;
  logic [TW-1:0] tog;
  logic          tick;

  always_comb begin
    case (rate)
      2'b00:   reload = CW'(DIV_R0 / 2 - 1);
      2'b01:   reload = CW'(DIV_R1 / 2 - 1);
      2'b10:   reload = CW'(DIV_R2 / 2 - 1);
      default: reload = CW'(DIV_R3 / 2 - 1);
    endcase
  end

  assign tick = active && (cnt == '0);
  assign rise = tick && !sck;
  assign fall = tick && sck;
  assign done = tick && (tog == TW'(TOGGLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      tog    <= '0;
      sck    <= 1'b1;
    end else if (halt) begin
      active <= 1'b0;
      cnt    <= '0;
      tog    <= '0;
      sck    <= !idle_low;
    end else if (!active) begin
      sck <= !idle_low;
      if (start) begin
        active <= 1'b1;
        cnt    <= reload;
        tog    <= '0;
      end
    end else if (tick) begin
      sck <= !sck;
      cnt <= reload;
      tog <= tog + 1'b1;
      if (done) active <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sio_sck_sync.sv
module sio_sck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], sck_async};
      last  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] && !last;
  assign fall = !chain[STAGES-1] && last;
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         is_master,
  input  logic         rise,
  input  logic         fall,
  input  logic         master_done,
  input  logic         sdi,
  output logic         sdo,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_byte
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  tx_sr, rx_sr, rx_next;
  logic [CW-1:0] cnt;
  logic          last_rise, may_shift;

  assign rx_next   = lsb_first ? {sdi, rx_sr[W-1:1]} : {rx_sr[W-2:0], sdi};
  assign last_rise = rise && (cnt == CW'(W - 1));
  assign done      = !clear && (is_master ? master_done : last_rise);
  assign may_shift = fall && (cnt != '0) && (cnt < CW'(W));
  assign sdo       = lsb_first ? tx_sr[0] : tx_sr[W-1];
  assign busy      = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      rx_byte <= '0;
      cnt     <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else begin
      if (load) tx_sr <= load_data;
      if (rise) begin
        rx_sr <= rx_next;
        if (cnt < CW'(W)) cnt <= cnt + 1'b1;
      end
      if (may_shift)
        tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
      if (done) begin
        cnt     <= '0;
        rx_byte <= rise ? rx_next : rx_sr;
      end
    end
  end
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DIV_R0      = 64,
  parameter int DIV_R1      = 32,
  parameter int DIV_R2      = 16,
  parameter int DIV_R3      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] ctrl_wdata,
  output logic [BYTE_W-1:0] ctrl_rdata,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              done_flag,
  output logic              irq,
  output logic              pin_sel,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              sdo
);
  sio_cfg_t cfg;
  logic abort, finish, load, start;
  logic m_sck, m_active, m_rise, m_fall, m_done;
  logic s_rise, s_fall, sh_busy, sh_sdo;
  logic rise, fall;

  sio_ctrl_reg u_ctrl (
    .clk, .rst_n, .we(ctrl_we), .wdata(ctrl_wdata), .finish,
    .cfg, .flag(done_flag), .abort, .rdata(ctrl_rdata)
  );

  sio_clkgen #(
    .DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3),
    .BITS(BYTE_W)
  ) u_clk (
    .clk, .rst_n, .halt(abort || !cfg.master), .start,
    .rate(cfg.rate), .idle_low(cfg.idle_low),
    .sck(m_sck), .active(m_active), .rise(m_rise), .fall(m_fall), .done(m_done)
  );

  sio_sck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .sck_async(sck_in), .rise(s_rise), .fall(s_fall)
  );

  assign rise = cfg.master ? m_rise : s_rise;
  assign fall = cfg.master ? m_fall : s_fall;

  sio_shifter #(.W(BYTE_W)) u_shift (
    .clk, .rst_n, .clear(abort), .load, .load_data(tx_data),
    .lsb_first(cfg.lsb_first), .is_master(cfg.master),
    .rise, .fall, .master_done(m_done), .sdi,
    .sdo(sh_sdo), .busy(sh_busy), .done(finish), .rx_byte(rx_data)
  );

  assign tx_ready = cfg.enable && !abort && !m_active && !sh_busy;
  assign load     = tx_valid && tx_ready;
  assign start    = load && cfg.master;
  assign irq      = done_flag;
  assign pin_sel  = cfg.enable;
  assign sck_oe   = cfg.enable && cfg.master;
  assign sck_out  = (sck_oe && m_active) ? m_sck : !cfg.idle_low;
  assign sdo      = cfg.enable ? sh_sdo : 1'b0;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic [7:0] ctrl_rdata,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic [7:0] rx_data,
  input logic       done_flag,
  input logic       irq,
  input logic       pin_sel,
  input logic       sck_in,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       sdi,
  input logic       sdo
);
  // R2
  oe_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_oe |-> pin_sel);

  // R3
  ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_sel |-> !tx_ready);

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && sck_oe) |-> (sck_out == !ctrl_rdata[4]));

  // R6
  sdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && sck_out && $past(sck_out)
     && !$past(tx_valid && tx_ready) && !$past(ctrl_we)) |-> $stable(sdo));

  // R8
  strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rdata[3]);

  // R10
  no_done_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_sel |=> !$rose(done_flag));
endmodule

bind sio_port sio_port_chk u_chk (.*);

// File: tb/tb_sio_port.sv
module tb_sio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_rdata;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       done_flag, irq, pin_sel, sck_out, sck_oe, sdo;
  logic       sck_in = 1'b0;
  logic       sdi = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = !clk;

  sio_port dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cb(bit en, bit lsb, bit mst, bit clr, bit idl, logic [1:0] rt);
    return {1'b0, rt, idl, clr, mst, lsb, en};
  endfunction

  task automatic wr(input logic [7:0] d);
    ctrl_we = 1'b1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, output bit acc);
    tx_valid = 1'b1; tx_data = d; acc = tx_ready;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] inb, input bit lsb,
                        input bit busy_poke, output logic [7:0] got, output bit acc);
    int r = 0;
    int guard = 0;
    bit prev;
    bit dummy;
    got = '0;
    sdi = lsb ? inb[0] : inb[7];
    push(tx, acc);
    prev = sck_out;
    while (!done_flag && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (busy_poke && r == 3) begin
        chk(tx_ready == 1'b0, "R9 ready during transfer", tx_ready, 0);
        push(8'hFF, dummy);
        busy_poke = 0;
      end
      if (sck_out && !prev) begin
        if (r < 8) got[lsb ? r : 7 - r] = sdo;
        r++;
      end else if (!sck_out && prev && r > 0 && r < 8) begin
        sdi = lsb ? inb[r] : inb[7 - r];
      end
      prev = sck_out;
    end
  endtask

  task automatic t_reset;
    chk(ctrl_rdata == 8'h00, "R1 ctrl", ctrl_rdata, 0);
    chk({done_flag, irq, pin_sel, sck_oe} == 4'b0, "R1 outputs", {done_flag, irq, pin_sel, sck_oe}, 0);
  endtask

  task automatic t_layout;
    wr(cb(1, 1, 0, 1, 1, 2'b10));
    chk(ctrl_rdata == 8'h53, "R2 readback", ctrl_rdata, 8'h53);
    chk(pin_sel && !sck_oe, "R2 slave pins", {pin_sel, sck_oe}, 2'b10);
    wr(cb(1, 0, 1, 0, 0, 2'b00));
    chk(pin_sel && sck_oe, "R2 master pins", {pin_sel, sck_oe}, 2'b11);
  endtask

  task automatic t_master_msb;
    logic [7:0] got; bit acc;
    wr(cb(1, 0, 1, 1, 0, 2'b11));
    chk(sck_out == 1'b1, "R6 idle high", sck_out, 1);
    m_xfer(8'hA5, 8'h3C, 0, 0, got, acc);
    chk(acc, "R3 accepted", acc, 1);
    chk(got == 8'hA5, "R3 sdo msb-first", got, 8'hA5);
    chk(rx_data == 8'h3C, "R7 rx byte", rx_data, 8'h3C);
    chk(done_flag && irq, "R7 flag irq", {done_flag, irq}, 2'b11);
    repeat (2) @(negedge clk);
    chk(sck_out == 1'b1, "R6 back to idle high", sck_out, 1);
  endtask

  task automatic t_flag;
    wr(cb(1, 0, 1, 0, 0, 2'b11));
    chk(done_flag == 1'b1, "R8 zero strobe keeps flag", done_flag, 1);
    wr(cb(1, 0, 1, 1, 0, 2'b11));
    chk(done_flag == 1'b0 && irq == 1'b0, "R8 strobe clears", {done_flag, irq}, 0);
    chk(ctrl_rdata[3] == 1'b0, "R8 strobe reads 0", ctrl_rdata[3], 0);
  endtask

  task automatic t_master_lsb;
    logic [7:0] got; bit acc;
    wr(cb(1, 1, 1, 1, 1, 2'b10));
    chk(sck_out == 1'b0, "R6 idle low", sck_out, 0);
    m_xfer(8'h1E, 8'hC4, 1, 0, got, acc);
    chk(got == 8'h1E, "R4 sdo lsb-first", got, 8'h1E);
    chk(rx_data == 8'hC4, "R4 rx lsb-first", rx_data, 8'hC4);
    repeat (2) @(negedge clk);
    chk(sck_out == 1'b0, "R7 idle low after", sck_out, 0);
  endtask

  task automatic t_busy_write;
    logic [7:0] got; bit acc;
    wr(cb(1, 0, 1, 1, 0, 2'b10));
    m_xfer(8'h69, 8'h96, 0, 1, got, acc);
    chk(got == 8'h69, "R9 byte unchanged", got, 8'h69);
    chk(rx_data == 8'h96, "R9 rx intact", rx_data, 8'h96);
  endtask

  task automatic t_rate(input logic [1:0] rt, input int half);
    bit acc; bit prev; int n = 0; int t = 0; int g = 0;
    wr(cb(1, 0, 1, 1, 1, rt));
    push(8'h00, acc);
    prev = sck_out;
    while (t < 2 && g < 400) begin
      @(negedge clk); g++;
      if (t == 1) n++;
      if (sck_out != prev) t++;
      prev = sck_out;
    end
    chk(n == half, "R5 half period", n, half);
    g = 0;
    while (!done_flag && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic t_abort(input bit by_enable);
    logic [7:0] got; bit acc; int g = 0;
    wr(cb(1, 0, 1, 1, 0, 2'b00));
    push(8'hF0, acc);
    repeat (100) @(negedge clk);
    if (by_enable) begin
      wr(cb(0, 0, 1, 0, 0, 2'b00));
      chk(!pin_sel && !sck_oe, "R10 pins released", {pin_sel, sck_oe}, 0);
    end else begin
      wr(cb(1, 0, 0, 0, 0, 2'b00));
      chk(!sck_oe && tx_ready, "R11 clock released and ready", {sck_oe, tx_ready}, 2'b01);
    end
    repeat (700) @(negedge clk);
    chk(!done_flag, by_enable ? "R10 no completion" : "R11 no completion", done_flag, 0);
    wr(cb(1, 0, 1, 0, 0, 2'b11));
    chk(tx_ready, "R10 ready again", tx_ready, 1);
    m_xfer(8'h5A, 8'hE1, 0, 0, got, acc);
    chk(got == 8'h5A && rx_data == 8'hE1, by_enable ? "R10 clean restart" : "R11 clean restart",
        {got, rx_data}, 16'h5AE1);
  endtask

  task automatic t_slave;
    bit acc; logic [7:0] got = '0;
    logic [7:0] inb = 8'h2D;
    wr(cb(1, 0, 0, 1, 1, 2'b00));
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    push(8'hB3, acc);
    chk(acc, "R12 preload accepted", acc, 1);
    for (int k = 0; k < 8; k++) begin
      sdi = inb[7 - k];
      repeat (6) @(negedge clk);
      got[7 - k] = sdo;
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      if (k == 3) chk(!tx_ready, "R12 busy mid-byte", tx_ready, 0);
      sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(got == 8'hB3, "R12 slave sdo", got, 8'hB3);
    chk(rx_data == 8'h2D && done_flag, "R12 slave rx", {done_flag, rx_data}, 9'h12D);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_master_msb;
    t_flag;
    t_master_lsb;
    t_busy_write;
    t_rate(2'b00, 32);
    t_rate(2'b01, 16);
    t_rate(2'b10, 8);
    t_rate(2'b11, 2);
    t_abort(1);
    t_abort(0);
    t_slave;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule